// File: doc/BRIEF.md
# Delayed-Start Serial Word Receiver

This block turns a serial bit stream into parallel words. Each frame sync pulse is a start marker. It does not mark a window in which data is valid. When a sync is seen, the block counts a selectable number of bit periods (0, 1 or 2) and then collects exactly one word, MSB first. The finished word is presented together with a valid strobe that lasts one clock.

All stream inputs are qualified by a bit-clock enable that is synchronous to the system clock. The start delay is kept in its own small countdown, separate from the bit counter. Because of this, a sync can arrive while the final bits of the previous word are still being shifted in, and the next word still begins on the correct bit. Syncs spaced exactly one word length apart therefore give a gap-free stream, whatever the delay.

A sync that arrives while an earlier start is still counting down is a sign of framing trouble. It raises a one-clock misalignment pulse, and the newer sync takes over.

Top module: `rx_word_deser`

## Requirements
- R1: While reset is held and after it is released, `word_out` is all zeros and `word_valid` and `misalign` are low.
- R2: After reset, no word is produced until the first frame sync has been sampled, however much data arrives with `bit_en` high.
- R3: With `dly_sel` = 0, the bit sampled on the same `bit_en` cycle as the sync is the first bit of the word. The first bit lands in `word_out` bit WORD_W-1 (MSB first), and exactly WORD_W bits are collected.
- R4: With `dly_sel` = 1, the first bit of the word is the bit sampled on the next `bit_en` cycle after the sync.
- R5: With `dly_sel` = 2, the first bit is sampled two `bit_en` cycles after the sync. Syncs spaced WORD_W `bit_en` cycles apart overlap the tail of the previous word. Every such word is still received intact, and no misalignment is flagged.
- R6: `dly_sel` is sampled together with each sync, and the value 3 acts as a delay of 2.
- R7: `fsync` and `sdata` are sampled only on cycles where `bit_en` is high. Their values on other cycles have no effect.
- R8: `word_valid` is high for exactly one clock. That clock is the one after the `bit_en` edge that samples the word's last bit. `word_out` holds the word until the next strobe.
- R9: A sync sampled while an earlier start still has two or more `bit_en` cycles left to count gives a one-clock `misalign` pulse. The newer sync replaces the pending start.
- R10: A start that takes effect before the current word has all its bits discards the partial word. Only the new word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_en | input | 1 | Bit-clock enable; qualifies `sdata` and `fsync` |
| sdata | input | 1 | Serial data line |
| fsync | input | 1 | Frame sync start marker |
| dly_sel | input | DLY_W (2) | Start delay in bit periods, sampled with each sync |
| word_out | output | WORD_W (32) | Last completed word, MSB first |
| word_valid | output | 1 | One-clock strobe marking a new word |
| misalign | output | 1 | One-clock pulse on an early, overlapping sync |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a largest delay of 2. With these values the hard case is reachable: syncs exactly one word apart, where each new sync lands two bits before the previous word ends. The bench also checks the clamped delay code, enable gaps in which sync is held high, a sync arriving one bit after another, and a restart that cuts a word short. For every bit period it compares the strobe against the bit on which each word ends.

// File: rtl/rx_pkg.sv
package rx_pkg;
  parameter int unsigned RXD_WORD_W  = 32;
  parameter int unsigned RXD_MAX_DLY = 2;
  localparam int unsigned RXD_DLY_W  = $clog2(RXD_MAX_DLY + 1);

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_BUSY = 1'b1
  } cap_state_e;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rx_start_ctrl.sv
module rx_start_ctrl #(
  parameter int unsigned MAX_DLY = 2,
  parameter int unsigned DLY_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             start_now,
  output logic             misalign
);
  localparam logic [DLY_W-1:0] DLY_CAP = DLY_W'(MAX_DLY);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  logic             pend_act_q, pend_act_d;
  logic [DLY_W-1:0] pend_cnt_q, pend_cnt_d;
  logic             mis_q, mis_d;
  logic [DLY_W-1:0] dly_eff;
  logic             sync_now, pend_fire, pend_last;

  always_comb begin
    dly_eff   = (dly_sel > DLY_CAP) ? DLY_CAP : dly_sel;
    sync_now  = bit_en & fsync;
    pend_last = pend_act_q & (pend_cnt_q == DLY_ONE);
    pend_fire = bit_en & pend_last;
    start_now = (sync_now & (dly_eff == '0)) | pend_fire;
    mis_d     = sync_now & pend_act_q & ~pend_last;
  end

  always_comb begin
    pend_act_d = pend_act_q;
    pend_cnt_d = pend_cnt_q;
    if (bit_en) begin
      if (pend_act_q) begin
        if (pend_last) pend_act_d = 1'b0;
        else           pend_cnt_d = pend_cnt_q - DLY_ONE;
      end
      if (fsync) begin
        pend_act_d = (dly_eff != '0);
        pend_cnt_d = dly_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_act_q <= 1'b0;
      pend_cnt_q <= '0;
      mis_q      <= 1'b0;
    end else begin
      pend_act_q <= pend_act_d;
      pend_cnt_q <= pend_cnt_d;
      mis_q      <= mis_d;
    end
  end

  assign misalign = mis_q;

  assert_pend_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_act_q |-> (pend_cnt_q != '0) && (pend_cnt_q <= DLY_CAP));

  assert_misalign_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(bit_en && fsync));

  assert_misalign_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !misalign);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sdata,
  input  logic              start,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  cap_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (bit_en) begin
      if (start) begin
        sh_d  = {{(WORD_W-1){1'b0}}, sdata};
        cnt_d = ONE;
        st_d  = CAP_BUSY;
      end else if (st_q == CAP_BUSY) begin
        sh_d = {sh_q[WORD_W-2:0], sdata};
        if (cnt_q == LAST) begin
          st_d    = CAP_IDLE;
          cnt_d   = '0;
          valid_d = 1'b1;
          word_d  = {sh_q[WORD_W-2:0], sdata};
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CAP_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_valid_after_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(bit_en));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (valid || $stable(word)));

  assert_busy_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_BUSY) |-> (cnt_q != '0));
endmodule

// File: rtl/rx_word_deser.sv
module rx_word_deser
  import rx_pkg::*;
#(
  parameter int unsigned WORD_W  = RXD_WORD_W,
  parameter int unsigned MAX_DLY = RXD_MAX_DLY,
  parameter int unsigned DLY_W   = $clog2(MAX_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sdata,
  input  logic              fsync,
  input  logic [DLY_W-1:0]  dly_sel,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              misalign
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic rst_n_i;
  logic start_now;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  rx_start_ctrl #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .dly_sel   (dly_sel),
    .start_now (start_now),
    .misalign  (misalign)
  );

  rx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .bit_en (bit_en),
    .sdata  (sdata),
    .start  (start_now),
    .word   (word_out),
    .valid  (word_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_i |-> (!word_valid && !misalign));
endmodule

// File: tb/tb_rx_word_deser.sv
module tb_rx_word_deser;
  localparam int W  = 32;
  localparam int NB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, sdata = 1'b0, fsync = 1'b0;
  logic [1:0] dly_sel = 2'd0;
  logic [W-1:0] word_out;
  logic word_valid, misalign;

  always #4 clk = ~clk;

  rx_word_deser dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdata(sdata), .fsync(fsync),
    .dly_sel(dly_sel), .word_out(word_out), .word_valid(word_valid), .misalign(misalign)
  );

  bit fs_a [NB];
  bit d_a [NB];
  bit last_a [NB];
  int nb, n_exp, rx_n, mis_n, checks, fails, bad;
  logic [W-1:0] exp_w [8];
  logic [W-1:0] rx_w [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        if (rx_n < 16) rx_w[rx_n] = word_out;
        rx_n++;
      end
      if (misalign) mis_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wgen(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ 32'h5A5A0F0F;
  endfunction

  task automatic clear_stream();
    for (int i = 0; i < NB; i++) begin fs_a[i] = 0; d_a[i] = 0; last_a[i] = 0; end
    nb = 0; n_exp = 0; rx_n = 0; mis_n = 0;
  endtask

  task automatic add_word(input int pos, input int dly, input logic [W-1:0] w, input bit keep);
    fs_a[pos] = 1;
    for (int b = 0; b < W; b++) d_a[pos + dly + b] = w[W-1-b];
    if (keep) begin
      last_a[pos + dly + W - 1] = 1;
      exp_w[n_exp] = w;
      n_exp++;
    end
    if (pos + dly + W + 3 > nb) nb = pos + dly + W + 3;
  endtask

  task automatic drive(input logic [1:0] dsel, input int gap);
    bad = 0;
    dly_sel = dsel;
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bit_en = 1'b1; fsync = fs_a[i]; sdata = d_a[i];
      @(negedge clk);
      if (word_valid !== last_a[i]) bad++;
      for (int g = 0; g < gap; g++) begin
        bit_en = 1'b0; fsync = 1'b1; sdata = ~d_a[i];
        @(negedge clk);
        if (word_valid !== 1'b0) bad++;
      end
    end
    bit_en = 1'b0; fsync = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_words(input string req);
    chk(rx_n == n_exp, {req, " word count"}, rx_n, n_exp);
    for (int k = 0; k < n_exp; k++)
      chk(rx_w[k] === exp_w[k], {req, " word value"}, rx_w[k], exp_w[k]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(word_valid === 1'b0 && misalign === 1'b0 && word_out === '0, "R1 in reset",
        {word_valid, misalign, word_out[29:0]}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(word_valid === 1'b0 && misalign === 1'b0 && word_out === '0, "R1 after release",
        {word_valid, misalign, word_out[29:0]}, '0);
  endtask

  task automatic t_no_sync();
    clear_stream();
    nb = 90;
    for (int i = 0; i < nb; i++) d_a[i] = i[0] ^ i[2];
    drive(2'd0, 0);
    chk(rx_n == 0, "R2 words before sync", rx_n, 0);
    chk(word_out === '0, "R2 word_out untouched", word_out, '0);
  endtask

  task automatic t_delay(input int dly, input logic [1:0] dsel, input string req);
    clear_stream();
    for (int k = 0; k < 4; k++) add_word(3 + k * W, dly, wgen(k + dly * 7), 1);
    drive(dsel, 0);
    cmp_words(req);
    chk(bad == 0, {req, " R8 strobe timing"}, bad, 0);
    chk(mis_n == 0, {req, " no misalign"}, mis_n, 0);
  endtask

  task automatic t_gaps();
    clear_stream();
    add_word(2, 2, wgen(20), 1);
    add_word(2 + W, 2, wgen(21), 1);
    drive(2'd2, 2);
    cmp_words("R7 gapped enable");
    chk(bad == 0, "R7 R8 strobe timing with gaps", bad, 0);
    chk(mis_n == 0, "R7 sync outside enable ignored", mis_n, 0);
    chk(word_out === wgen(21), "R8 word held", word_out, wgen(21));
  endtask

  task automatic t_misalign();
    clear_stream();
    add_word(5, 2, wgen(30), 1);
    fs_a[4] = 1;
    drive(2'd2, 0);
    chk(mis_n == 1, "R9 misalign pulses", mis_n, 1);
    cmp_words("R9 newer sync wins");
    chk(bad == 0, "R9 strobe timing", bad, 0);
  endtask

  task automatic t_restart();
    clear_stream();
    add_word(2, 0, wgen(40), 0);
    add_word(22, 0, wgen(41), 1);
    drive(2'd0, 0);
    cmp_words("R10 partial word dropped");
    chk(bad == 0, "R10 strobe timing", bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    t_reset();
    t_no_sync();
    t_delay(0, 2'd0, "R3 delay0");
    t_delay(1, 2'd1, "R4 delay1");
    t_delay(2, 2'd2, "R5 delay2 overlap");
    t_delay(2, 2'd3, "R6 code3 as delay2");
    t_gaps();
    t_misalign();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule